// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave control port. An external controller uses it to read and write a small bank of 8-bit configuration registers over a four-wire serial link. The wires are a chip-select (active low), a serial clock, serial data in and serial data out. The output is tri-stateable and is modelled as a data pin plus an output-enable pin. Every access begins with a fixed 7-bit device address and a direction bit.

In a write access the next byte sets a persistent address pointer. That pointer byte also carries an auto-increment flag. Any further bytes are stored in the selected registers. A read is split into two frames. A short write frame ending right after the pointer byte positions the pointer. A separate read frame then streams register contents out, starting at that pointer.

The port runs entirely in the system clock domain. The serial pins pass through two-flop synchronizers followed by edge detection. The system clock must therefore run at least four times faster than the serial clock. The register contents are also presented in parallel to the rest of the chip.

Top module: `spi_reg_port`

## Requirements
- R1: Serial input bits are taken on rising serial-clock edges, most significant bit first. A frame opens with the 7-bit device address 1001111 followed by a direction bit (0 = write, 1 = read). In a write frame the next byte is the pointer byte, and every following complete byte is stored at the pointed register.
- R2: In the pointer byte, bit 7 is the auto-increment flag and bits 6:0 are the register address. The pointer persists across frames.
- R3: With the auto-increment flag at 1, the pointer advances by one after each data byte written, so a block write fills consecutive registers.
- R4: With the auto-increment flag at 0, the pointer does not move. Successive data bytes overwrite the same register, and a read frame returns the same register for every byte.
- R5: In a read frame, the first serial-clock falling edge after the direction bit drives the MSB of the pointed register. Output bits change only on falling edges, and bytes follow one another without a gap. With auto-increment set, each byte comes from the next address.
- R6: The output enable is low during write frames, between frames, and in a read frame before its first falling edge.
- R7: A frame whose device address is not 1001111 writes nothing and never enables the output until chip-select rises.
- R8: Raising chip-select aborts the frame at once. A partial data byte is discarded, but a pointer byte that was fully received is kept.
- R9: The bank holds 32 registers at addresses 0 to 31. Writes to addresses 32 to 127 are ignored, and reads of those addresses return 0x00. The 7-bit pointer wraps from 127 to 0.
- R10: Traffic that begins while chip-select is already low when reset is released is ignored. The port only starts a frame after it sees a high-to-low chip-select transition.
- R11: After reset all registers read 0x00, the pointer is 0, auto-increment is off, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low = high impedance) |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i in bits 8i+7:8i |

## Verification
The assertions assume the following about the serial pins:
- The system clock runs at least four times the serial clock.
- Data in is stable across each rising serial-clock edge.
- Chip-select never moves in the same few system cycles as a serial-clock edge.

With those inputs, the synchronized edges arrive in order and each one lasts a single cycle. The stimulus keeps a half period of eight system clocks. It sets data in while the serial clock is low and moves chip-select only half a period away from any clock edge. It parks the serial clock low only after chip-select has risen, so a frame never sees a stray trailing edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PTR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    // two sync stages plus one history stage; reset low so a pin held low at release gives no fall
    logic [2:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 3'b000;
      else         q <= {q[1:0], d_i[g]};
    end
    assign lvl_o[g]  = q[1];
    assign rise_o[g] = q[1] & ~q[2];
    assign fall_o[g] = ~q[1] & q[2];
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [PTR_W-1:0]           wa_i,
  input  logic [BYTE_W-1:0]          wd_i,
  input  logic [PTR_W-1:0]           ra_i,
  output logic [BYTE_W-1:0]          rd_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W:0] LIMIT = NUM_REGS[PTR_W:0];

  logic [BYTE_W-1:0] mem [NUM_REGS];
  logic ra_ok, wa_ok;

  assign ra_ok = {1'b0, ra_i} < LIMIT;
  assign wa_ok = {1'b0, wa_i} < LIMIT;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[i] <= '0;
      else if (we_i && wa_ok && wa_i[IDX_W-1:0] == IDX_W'(i)) mem[i] <= wd_i;
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = mem[i];
  end

  assign rd_o = ra_ok ? mem[ra_i[IDX_W-1:0]] : '0;

  a_r9_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wa_ok) |=> $stable(regs_o));
endmodule

// File: rtl/spi_reg_frame.sv
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter logic [PTR_W-1:0] CHIP_ADDR = 7'b1001111
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdi_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PTR_W-1:0]  rd_addr_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  frame_st_e         st_q;
  logic [2:0]        bit_cnt_q;
  logic [6:0]        sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              incr_q;
  logic              we_q;
  logic [PTR_W-1:0]  wa_q;
  logic [BYTE_W-1:0] wd_q;
  logic              sdo_q;
  logic              oe_q;

  logic [BYTE_W-1:0] byte_w;
  logic              last_bit;
  logic [PTR_W-1:0]  ptr_nxt;

  assign byte_w   = {sh_q, sdi_i};
  assign last_bit = (bit_cnt_q == 3'd7);
  assign ptr_nxt  = incr_q ? ptr_q + 7'd1 : ptr_q;
  // prefetch: header uses current pointer, streaming uses the following one
  assign rd_addr_o = (st_q == ST_RDAT) ? ptr_nxt : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      incr_q    <= 1'b0;
      we_q      <= 1'b0;
      wa_q      <= '0;
      wd_q      <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (cs_rise_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (cs_fall_i) begin
        st_q      <= ST_HDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (st_q)
          ST_HDR, ST_PTR, ST_WDAT: begin
            if (sclk_rise_i) begin
              sh_q      <= byte_w[6:0];
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (last_bit) begin
                unique case (st_q)
                  ST_HDR: begin
                    if (sh_q == CHIP_ADDR) begin
                      st_q <= sdi_i ? ST_RDAT : ST_PTR;
                      if (sdi_i) tx_q <= rd_data_i;
                    end else begin
                      st_q <= ST_SKIP;
                    end
                  end
                  ST_PTR: begin
                    incr_q <= byte_w[7];
                    ptr_q  <= byte_w[6:0];
                    st_q   <= ST_WDAT;
                  end
                  default: begin
                    we_q  <= 1'b1;
                    wa_q  <= ptr_q;
                    wd_q  <= byte_w;
                    ptr_q <= ptr_nxt;
                  end
                endcase
              end
            end
          end
          ST_RDAT: begin
            if (sclk_fall_i) begin
              oe_q      <= 1'b1;
              sdo_q     <= tx_q[7];
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (last_bit) begin
                tx_q  <= rd_data_i;
                ptr_q <= ptr_nxt;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign we_o      = we_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  a_r8_cs_rise_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> (st_q == ST_IDLE && !sdo_oe_o));
  a_r6_oe_only_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> (st_q == ST_RDAT));
  a_r7_skip_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> (!we_o && !sdo_oe_o));
  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WDAT && !incr_q) |=> $stable(ptr_q));
  a_r5_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall_i |=> $stable(sdo_o));
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int unsigned      NUM_REGS  = 32,
  parameter logic [PTR_W-1:0] CHIP_ADDR = 7'b1001111
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int unsigned N_PINS = 3;

  logic [N_PINS-1:0] pin_lvl, pin_rise, pin_fall;
  logic              we;
  logic [PTR_W-1:0]  wa, ra;
  logic [BYTE_W-1:0] wd, rd;

  spi_reg_sync #(.WIDTH(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, sclk_i, cs_ni}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  spi_reg_frame #(.CHIP_ADDR(CHIP_ADDR)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_rise_i   (pin_rise[0]),
    .cs_fall_i   (pin_fall[0]),
    .sclk_rise_i (pin_rise[1]),
    .sclk_fall_i (pin_fall[1]),
    .sdi_i       (pin_lvl[2]),
    .rd_data_i   (rd),
    .rd_addr_o   (ra),
    .we_o        (we),
    .wr_addr_o   (wa),
    .wr_data_o   (wd),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wa_i   (wa),
    .wd_i   (wd),
    .ra_i   (ra),
    .rd_o   (rd),
    .regs_o (regs_o)
  );

  a_r10_idle_until_cs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_lvl[0] && !pin_fall[0]) |=> !we);
endmodule

// File: tb/spi_reg_port_test.sv
`timescale 1ns/1ps
module spi_reg_port_test;
  localparam int NREG = 32;
  localparam time HALF = 64ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [NREG*8-1:0] regs;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] expv [NREG];
  logic [7:0] rbuf [40];
  logic oe_any, oe_all;

  always #4ns clk = ~clk;

  spi_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .regs_o(regs)
  );

  function automatic logic [7:0] dval(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp_v);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(regs[i*8 +: 8] == expv[i], req, regs[i*8 +: 8], expv[i]);
  endtask

  // shift nb bits of tx, MSB first; capture sdo just before each rising edge
  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sclk = 1'b0; sdi = tx[i];
      #HALF;
      rx[i] = sdo;
      oe_any |= sdo_oe;
      oe_all &= sdo_oe;
      sclk = 1'b1;
      #HALF;
    end
  endtask

  task automatic fbegin();
    cs_n = 1'b0; #HALF;
  endtask

  task automatic fend();
    cs_n = 1'b1; #HALF; sclk = 1'b0; #(2*HALF);
  endtask

  task automatic wr_frame(input logic [6:0] chip, input logic [7:0] ptrb, input int n, input int base);
    logic [7:0] rx;
    oe_any = 1'b0;
    fbegin();
    xbits({chip, 1'b0}, 8, rx);
    xbits(ptrb, 8, rx);
    for (int i = 0; i < n; i++) xbits(dval(base + i), 8, rx);
    fend();
  endtask

  task automatic rd_frame(input logic [6:0] chip, input int n);
    logic [7:0] rx;
    oe_any = 1'b0;
    fbegin();
    xbits({chip, 1'b1}, 8, rx);
    chk(!oe_any, "R6 oe low before first fall", oe_any, 0);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      xbits(8'h00, 8, rx);
      rbuf[i] = rx;
    end
    fend();
  endtask

  initial begin
    #(200000 * 8ns);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < NREG; i++) expv[i] = 8'h00;
    // R10: chip-select held low across reset release
    cs_n = 1'b0;
    #103ns;
    rst_n = 1'b1;
    #HALF;
    chk(!sdo_oe, "R11 oe low after reset", sdo_oe, 0);
    chk_regs("R11 regs zero after reset");
    oe_any = 1'b0;
    xbits(8'h9E, 8, rx); xbits(8'h03, 8, rx); xbits(8'hA5, 8, rx);
    fend();
    chk_regs("R10 no frame without cs fall");
    chk(!oe_any, "R10 output idle", oe_any, 0);

    // R11: pointer reset 0 -> read returns reg 0
    rd_frame(7'b1001111, 1);
    chk(rbuf[0] == 8'h00, "R11 ptr reset read", rbuf[0], 0);

    // R1 R2 R3: block write over whole bank
    wr_frame(7'b1001111, 8'h80, NREG, 0);
    for (int i = 0; i < NREG; i++) expv[i] = dval(i);
    chk(!oe_any, "R6 oe low in write", oe_any, 0);
    chk_regs("R3 block write");

    // R5: split read, block with increment
    wr_frame(7'b1001111, 8'h80, 0, 0);
    rd_frame(7'b1001111, NREG);
    chk(oe_all, "R5 oe high while streaming", oe_all, 1);
    for (int i = 0; i < NREG; i++) chk(rbuf[i] == expv[i], "R5 block read", rbuf[i], expv[i]);

    // R4: fixed pointer
    wr_frame(7'b1001111, 8'h05, 3, 100);
    expv[5] = dval(102);
    chk_regs("R4 overwrite same reg");
    rd_frame(7'b1001111, 3);
    for (int i = 0; i < 3; i++) chk(rbuf[i] == expv[5], "R4 repeated read", rbuf[i], expv[5]);

    // R7: wrong device address, write and read
    wr_frame(7'b1001110, 8'h07, 2, 200);
    chk_regs("R7 bad address no write");
    chk(!oe_any, "R7 oe low write", oe_any, 0);
    rd_frame(7'b0001111, 2);
    chk(!oe_any, "R7 oe low read", oe_any, 0);

    // R8: abort partial data byte
    fbegin();
    xbits(8'h9E, 8, rx); xbits(8'h89, 8, rx); xbits(dval(300), 8, rx); xbits(8'hFF, 4, rx);
    fend();
    expv[9] = dval(300);
    chk_regs("R8 partial byte dropped");
    // R8: pointer-only frame, then abort during header of a write
    wr_frame(7'b1001111, 8'h0C, 0, 0);
    fbegin(); xbits(8'h9E, 5, rx); fend();
    rd_frame(7'b1001111, 1);
    chk(rbuf[0] == expv[12], "R8 pointer kept", rbuf[0], expv[12]);

    // R9: out-of-range write and read
    wr_frame(7'b1001111, 8'h28, 1, 400);
    chk_regs("R9 oob write ignored");
    rd_frame(7'b1001111, 1);
    chk(rbuf[0] == 8'h00, "R9 oob read zero", rbuf[0], 0);
    // R9: pointer wrap 127 -> 0
    wr_frame(7'b1001111, 8'hFF, 2, 500);
    expv[0] = dval(501);
    chk_regs("R9 wrap write");
    // R9: read across bank end
    wr_frame(7'b1001111, 8'h9E, 0, 0);
    rd_frame(7'b1001111, 4);
    chk(rbuf[0] == expv[30], "R9 read 30", rbuf[0], expv[30]);
    chk(rbuf[1] == expv[31], "R9 read 31", rbuf[1], expv[31]);
    chk(rbuf[2] == 8'h00, "R9 read 32", rbuf[2], 0);
    chk(rbuf[3] == 8'h00, "R9 read 33", rbuf[3], 0);
    chk(!sdo_oe, "R6 oe low between frames", sdo_oe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule